// File: doc/BRIEF.md
# ADC Test Pattern Generator

This block sits in the sample path between an analog-to-digital converter and the output serializer. In normal operation it passes each 12-bit sample through with one register stage. When pattern mode is armed, it drops the live samples and sends programmed 12-bit words instead, so the receiving logic can check the digital link against known values. Any gating further down the path, such as burst framing, still acts on the words this block emits.

Software programs the block through a plain write port of address, data and strobe. A mode register holds a high-performance flag. Three pattern registers each carry one 12-bit word, and the first of them also carries a two-bit enable code. Pattern mode is live only while the high-performance flag is clear and the enable code matches. While it is live, the output cycles through the three words on every clock. A separate low-resolution input clears the least significant bits of every output word.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: While reset is held, `dataOut` is 0. Reset clears all three pattern registers and sets the high-performance flag to 1, so after reset the block is in live mode.
- R2: When pattern mode is off, `dataOut` at a clock edge equals the `adcSample` value captured at the previous edge.
- R3: Pattern mode is on only when both of these hold: bit 1 of the mode register (address 0x01) is 0, and bits 15:14 of the register at address 0x3C are 2'b10. The codes 2'b00, 2'b01 and 2'b11 leave the path in live mode.
- R4: Each pattern register (addresses 0x3C, 0x3D and 0x3E) supplies its bits 13:2 as the 12-bit word. Bits 1:0 of each register are ignored. Bits 15:14 of 0x3D and 0x3E are also ignored.
- R5: While pattern mode is on, each clock emits the next word in the order 0x3C, 0x3D, 0x3E, and the order then wraps back to 0x3C. The presets follow this order: all-zeros (0x8000/0x0000/0x0000), all-ones (0xBFFC/0x3FFC/0x3FFC), 0x555/0xAAA (0x9554/0x2AA8/0x1554) and 0xFFF/0x000 (0xBFFC/0x0000/0x3FFC).
- R6: Each time pattern mode is entered, the first word emitted is the 0x3C word.
- R7: While `lowRes` is 1 at an edge, bits 4:0 of the word registered at that edge are 0 and bits 11:5 are kept. This applies to both pattern words and live samples.
- R8: A write accepted at a clock edge has no effect on the word registered at that same edge. It takes effect from the next edge on.
- R9: Writes to any address other than 0x01, 0x3C, 0x3D and 0x3E change nothing. In the mode register, every bit except bit 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register write address |
| regWrData | input | 16 | Register write data |
| adcSample | input | 12 | Live converter sample |
| lowRes | input | 1 | Low-resolution output select |
| dataOut | output | 12 | Registered output word |

## Verification
The assertions assume that `adcSample` and `lowRes` are stable around each rising edge. They also assume that at most one register is written per cycle, as the write port implies. The stimulus drives every input on the falling edge and issues one write per cycle at most.

Several cases are swept exhaustively: every 12-bit live sample, every custom pattern value, and every enable code combined with both settings of the high-performance flag. Writes to unused addresses are taken from an LFSR, and the bench sends none to the four real registers through that path. The bench checks the output against a model built from the requirements.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int TPG_WORDS = 3;
  localparam int TPG_SEL_W = $clog2(TPG_WORDS);

  typedef struct packed {
    logic [TPG_WORDS-1:0] loadWord;
    logic                 patOn;
    logic [TPG_SEL_W-1:0] wordSel;
  } tpgStrobes_t;
endpackage

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_W     = 16,
  parameter int PERF_ADDR = 8'h01,
  parameter int BASE_ADDR = 8'h3C,
  parameter int HP_BIT    = 1,
  parameter logic [1:0] EN_CODE = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output tpgStrobes_t       strobes
);
  localparam logic [TPG_SEL_W-1:0] LAST_IDX = TPG_SEL_W'(TPG_WORDS - 1);

  logic                 perfHigh;
  logic [1:0]           enCode;
  logic [TPG_SEL_W-1:0] seqIdx;
  logic [TPG_WORDS-1:0] loadWord;
  logic                 perfWr;
  logic                 patOn;

  assign perfWr = regWrEn && (regAddr == ADDR_W'(PERF_ADDR));

  for (genvar i = 0; i < TPG_WORDS; i++) begin : g_dec
    assign loadWord[i] = regWrEn && (regAddr == ADDR_W'(BASE_ADDR + i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perfHigh <= 1'b1;
      enCode   <= 2'b00;
    end else begin
      if (perfWr)      perfHigh <= regWrData[HP_BIT];
      if (loadWord[0]) enCode   <= regWrData[REG_W-1 -: 2];
    end
  end

  assign patOn = !perfHigh && (enCode == EN_CODE);

  always_ff @(posedge clk) begin
    if (!rstN || !patOn) seqIdx <= '0;
    else if (seqIdx == LAST_IDX) seqIdx <= '0;
    else seqIdx <= seqIdx + 1'b1;
  end

  always_comb begin
    strobes.loadWord = loadWord;
    strobes.patOn    = patOn;
    strobes.wordSel  = seqIdx;
  end

  // R5
  seq_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqIdx <= LAST_IDX);

  // R6
  entry_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(patOn) |-> seqIdx == '0);

  // R5
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    patOn && $past(patOn) |-> seqIdx != $past(seqIdx));

  // R3
  hp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    perfWr && regWrData[HP_BIT] |=> !patOn);
endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int REG_W      = 16,
  parameter int FIELD_LSB  = 2,
  parameter int LORES_KEEP = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  tpgStrobes_t         strobes,
  input  logic [REG_W-1:0]    regWrData,
  input  logic [SAMPLE_W-1:0] adcSample,
  input  logic                lowRes,
  output logic [SAMPLE_W-1:0] dataOut
);
  localparam int DROP_W = SAMPLE_W - LORES_KEEP;
  localparam logic [SAMPLE_W-1:0] LO_MASK = {{LORES_KEEP{1'b1}}, {DROP_W{1'b0}}};

  logic [SAMPLE_W-1:0] words [TPG_WORDS];
  logic [SAMPLE_W-1:0] chosen;
  logic [SAMPLE_W-1:0] outNext;

  for (genvar i = 0; i < TPG_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) words[i] <= '0;
      else if (strobes.loadWord[i]) words[i] <= regWrData[FIELD_LSB +: SAMPLE_W];
    end
  end

  always_comb begin
    chosen  = words[strobes.wordSel];
    outNext = strobes.patOn ? chosen : adcSample;
    if (lowRes) outNext = outNext & LO_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataOut <= '0;
    else       dataOut <= outNext;
  end

  // R7
  lores_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(lowRes) |-> dataOut[DROP_W-1:0] == '0);

  // R2
  live_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strobes.patOn) && !$past(lowRes) |-> dataOut == $past(adcSample));
endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen #(
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 16,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  input  logic [SAMPLE_W-1:0] adcSample,
  input  logic                lowRes,
  output logic [SAMPLE_W-1:0] dataOut
);
  tpg_pkg::tpgStrobes_t strobes;

  tpg_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobes(strobes)
  );

  tpg_datapath #(.SAMPLE_W(SAMPLE_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .adcSample(adcSample), .lowRes(lowRes), .dataOut(dataOut)
  );
endmodule

// File: tb/tb_adc_test_pattern_gen.sv
`timescale 1ns/1ps
module tb_adc_test_pattern_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [11:0] adcSample = '0;
  logic        lowRes = 1'b0;
  logic [11:0] dataOut;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  logic       mHp;
  logic [1:0] mEn;
  logic [11:0] mW [3];
  int         mIdx;

  always #4 clk = ~clk;

  adc_test_pattern_gen dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .adcSample(adcSample), .lowRes(lowRes), .dataOut(dataOut)
  );

  task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: dataOut=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, check after the following posedge
  task automatic cyc(input logic wr, input logic [7:0] a, input logic [15:0] d,
                     input logic [11:0] adc, input logic lr, input string tag);
    logic on;
    logic [11:0] exp;
    regWrEn = wr; regAddr = a; regWrData = d; adcSample = adc; lowRes = lr;
    on  = !mHp && (mEn == 2'b10);
    exp = on ? mW[mIdx] : adc;
    if (lr) exp = exp & 12'hFE0;
    mIdx = on ? ((mIdx == 2) ? 0 : mIdx + 1) : 0;
    if (wr) begin
      if (a == 8'h01) mHp = d[1];
      if (a == 8'h3C) begin mEn = d[15:14]; mW[0] = d[13:2]; end
      if (a == 8'h3D) mW[1] = d[13:2];
      if (a == 8'h3E) mW[2] = d[13:2];
    end
    @(posedge clk); #2;
    check(dataOut, exp, tag);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 12'h3A7, 1'b0, "R8");
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 16'h0, 12'((i * 331) ^ 12'h5C3), 1'b0, tag);
  endtask

  task automatic preset(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    wr(8'h01, 16'h0001);
    wr(8'h3C, 16'h0000);
    wr(8'h3D, b);
    wr(8'h3E, c);
    wr(8'h3C, a);
    idle(7, "R5");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    mHp = 1'b1; mEn = 2'b00; mIdx = 0;
    for (int i = 0; i < 3; i++) mW[i] = '0;
    adcSample = 12'hABC;
    repeat (3) @(negedge clk);
    check(dataOut, 12'h000, "R1");
    rstN = 1'b1;
    idle(4, "R1");

    // R2 / R7: every live sample, low-resolution alternating
    for (int v = 0; v < 4096; v++)
      cyc(1'b0, 8'h00, 16'h0, 12'(v), v[0], v[0] ? "R7" : "R2");

    // R3: every enable code with both flag settings, noise bits in mode register (R9)
    for (int code = 0; code < 4; code++) begin
      for (int hp = 0; hp < 2; hp++) begin
        wr(8'h01, (16'hA5A5 & 16'hFFFD) | 16'(hp << 1));
        wr(8'h3C, {2'(code), 12'h5A5, 2'b11});
        idle(4, "R3");
      end
    end

    // R5: presets
    preset(16'h8000, 16'h0000, 16'h0000);
    preset(16'hBFFC, 16'h3FFC, 16'h3FFC);
    preset(16'h9554, 16'h2AA8, 16'h1554);
    preset(16'hBFFC, 16'h0000, 16'h3FFC);

    // R6: leave and re-enter after different run lengths
    for (int k = 1; k < 6; k++) begin
      idle(k, "R5");
      wr(8'h01, 16'h0002);
      idle(2, "R2");
      wr(8'h01, 16'h0000);
      idle(3, "R6");
    end

    // R4: every custom value, with junk in ignored bit positions
    for (int v = 0; v < 4096; v++) begin
      cyc(1'b1, 8'h3D, {2'b11, ~12'(v), 2'b11}, 12'h111, 1'b0, "R4");
      cyc(1'b1, 8'h3E, {2'b01, 12'(v) ^ 12'h3C3, 2'b10}, 12'h222, v[1], "R4");
      cyc(1'b1, 8'h3C, {2'b10, 12'(v), 2'b01}, 12'h333, 1'b0, "R4");
      for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 16'h0, 12'h444, v[2], "R4");
    end

    // R9: writes to unused addresses while in pattern mode
    lfsr = 8'h5B;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr != 8'h01 && lfsr != 8'h3C && lfsr != 8'h3D && lfsr != 8'h3E)
        cyc(1'b1, lfsr, {lfsr, ~lfsr}, 12'(i), 1'b0, "R9");
      else
        cyc(1'b0, 8'h00, 16'h0, 12'(i), 1'b0, "R9");
    end

    // return to normal sampling
    wr(8'h01, 16'h0002);
    wr(8'h3C, 16'h0000);
    wr(8'h3D, 16'h0000);
    wr(8'h3E, 16'h0000);
    idle(6, "R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule